// File: doc/BRIEF.md
# Reorder Buffer with Dataflow Issue

This block is the instruction window of an out-of-order core. Decode places each renamed operation into the slot at the tail of a circular buffer of eight entries. The index of that slot becomes the tag that later consumers use to name the result. A slot records the operation code and two source operands, each with a present flag. It also records whether the operation writes a register, the architectural register it writes, the result data and an exception cause.

Every cycle the buffer offers one slot to execution. The chosen slot must hold a valid operation that has not yet been sent, and both of its operands must be present. When several slots qualify, the oldest one counted from the head is chosen. Execution units return results on a completion bus that carries a tag, data and cause. The buffer stores the data in the tagged slot and delivers it to every operand waiting on that tag.

The head slot retires in program order once it has completed. A retiring slot with a nonzero cause empties the whole window. A flush input also empties the window, without retiring anything in that cycle.

Top module: `dfw_rob`

## Requirements
- R1: After synchronous reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `iss_valid` and `cmt_valid` are 0.
- R2: `disp_tag` shows the slot that the next dispatch takes. Tags are handed out as 0,1,2,…,7 and then wrap to 0. After an exception drain or a flush they continue from the restart point given in R10 and R11.
- R3: `disp_ready` is 0 while all 8 slots are held, or while a flush or an exception retirement happens in the same cycle. A dispatch offered while `disp_ready` is 0 is ignored and does not change later tags.
- R4: A slot is offered on the issue port (`iss_valid`, `iss_tag`, `iss_op`, `iss_a`, `iss_b`) only if it holds an operation that has not been issued and both operands are present. An issue is always taken, in the cycle it is offered.
- R5: A slot is issued at most once per dispatch.
- R6: When several slots are ready, the one nearest the head in program order is issued.
- R7: A completion (`cmp_valid`, `cmp_tag`) writes `cmp_data` into every source operand still waiting on `cmp_tag` and marks that operand present. From the next cycle the waiting slot may issue with that value.
- R8: A completion in the same cycle as a dispatch whose source names the completing tag is forwarded into the new slot. That source arrives present with `cmp_data`.
- R9: Retirement (`cmt_valid`) happens only for the head slot, and no earlier than the cycle after its completion. It happens strictly in tag order and reports the slot's write flag, architectural register, result and cause.
- R10: When the retiring slot has a nonzero cause, all other slots are dropped. None of them ever issues or retires, and the next dispatch receives tag head+1.
- R11: While `flush_in` is 1, nothing retires and nothing issues. The next cycle the buffer is empty and the next dispatch receives the tag of the old head.
- R12: A source offered as ready at dispatch is stored with its value and marked present, so the slot can issue the cycle after dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_op | input | 6 | Operation code |
| disp_a_rdy | input | 1 | Source A value supplied |
| disp_a_tag | input | 3 | Producer tag of source A when not ready |
| disp_a_val | input | 32 | Source A value when ready |
| disp_b_rdy | input | 1 | Source B value supplied |
| disp_b_tag | input | 3 | Producer tag of source B when not ready |
| disp_b_val | input | 32 | Source B value when ready |
| disp_dvld | input | 1 | Operation writes a register |
| disp_arch | input | 5 | Architectural destination register |
| disp_tag | output | 3 | Tag the next dispatch receives |
| iss_valid | output | 1 | A slot is sent to execution |
| iss_tag | output | 3 | Tag of the issued slot |
| iss_op | output | 6 | Operation of the issued slot |
| iss_a | output | 32 | Source A value |
| iss_b | output | 32 | Source B value |
| cmp_valid | input | 1 | Completion broadcast |
| cmp_tag | input | 3 | Tag of the completing slot |
| cmp_data | input | 32 | Result value |
| cmp_cause | input | 4 | Exception cause, 0 for none |
| cmt_valid | output | 1 | Head slot retires |
| cmt_tag | output | 3 | Tag of the retiring slot |
| cmt_dvld | output | 1 | Retiring slot writes a register |
| cmt_arch | output | 5 | Architectural destination |
| cmt_data | output | 32 | Result value |
| cmt_cause | output | 4 | Exception cause |
| flush_in | input | 1 | Empty the buffer |

## Verification
The window is driven with ready-operand bursts, which show tag order and oldest-first selection. A fill past eight slots with results held back separates a correct stall from a wrapped tail. A producer that completes in the same cycle as a consumer is dispatched shows whether the bypass into a fresh slot works. Completions arriving out of order show that retirement still waits for the head. Long random runs mix dependent chains, out-of-order results, rare exception causes and flushes, and compare every output each cycle against a reference model in the bench, which exposes wrong wakeup, lost operands and pointer errors after a drain.

// File: rtl/dfw_pkg.sv
package dfw_pkg;

    localparam int NSLOT = 8;
    localparam int TAGW  = $clog2(NSLOT);
    localparam int OPW   = 6;
    localparam int DATW  = 32;
    localparam int ARCW  = 5;
    localparam int CAUW  = 4;

    typedef logic [TAGW-1:0] tag_t;
    typedef logic [OPW-1:0]  op_t;
    typedef logic [DATW-1:0] data_t;
    typedef logic [ARCW-1:0] arch_t;
    typedef logic [CAUW-1:0] cause_t;

    typedef struct packed {
        logic  here;
        tag_t  tag;
        data_t val;
    } opnd_t;

    typedef struct packed {
        logic   busy;
        logic   exec_b;
        logic   done_b;
        op_t    op;
        opnd_t  a;
        opnd_t  b;
        logic   dvld;
        arch_t  arch;
        data_t  res;
        cause_t cause;
    } slot_t;

    // capture a broadcast result into an operand that waits on its tag
    function automatic opnd_t snoop(opnd_t o, logic bv, tag_t bt, data_t bd);
        opnd_t r;
        r = o;
        if (!o.here && bv && (o.tag == bt)) begin
            r.here = 1'b1;
            r.val  = bd;
        end
        return r;
    endfunction

    function automatic logic slot_ready(slot_t s);
        return s.busy && !s.exec_b && s.a.here && s.b.here;
    endfunction

endpackage

// File: rtl/dfw_pick.sv
module dfw_pick
    import dfw_pkg::*;
(
    input  logic [TAGW-1:0]  head,
    input  logic [NSLOT-1:0] rdy,
    output logic             found,
    output logic [TAGW-1:0]  pick
);

    tag_t idx;

    // walk from youngest to oldest so the oldest ready slot wins
    always_comb begin
        found = 1'b0;
        pick  = head;
        idx   = head;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            idx = head + tag_t'(i);
            if (rdy[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

endmodule

// File: rtl/dfw_ctl.sv
module dfw_ctl
    import dfw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  logic            retire,
    input  logic            flush,
    input  logic            exc,
    output logic [TAGW-1:0] head,
    output logic [TAGW-1:0] tail,
    output logic            full,
    output logic            empty
);

    tag_t head_q, tail_q;
    logic full_q;
    tag_t head_inc, tail_inc;

    assign head_inc = head_q + tag_t'(1);
    assign tail_inc = tail_q + tag_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            full_q <= 1'b0;
        end else if (flush) begin
            tail_q <= head_q;
            full_q <= 1'b0;
        end else if (exc) begin
            head_q <= head_inc;
            tail_q <= head_inc;
            full_q <= 1'b0;
        end else begin
            if (alloc)  tail_q <= tail_inc;
            if (retire) head_q <= head_inc;
            if (alloc && !retire && (tail_inc == head_q))
                full_q <= 1'b1;
            else if (retire && !alloc)
                full_q <= 1'b0;
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign full  = full_q;
    assign empty = (head_q == tail_q) && !full_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        full |-> !alloc); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        empty |-> !retire); // R9

endmodule

// File: rtl/dfw_rob.sv
module dfw_rob
    import dfw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            disp_valid,
    output logic            disp_ready,
    input  logic [OPW-1:0]  disp_op,
    input  logic            disp_a_rdy,
    input  logic [TAGW-1:0] disp_a_tag,
    input  logic [DATW-1:0] disp_a_val,
    input  logic            disp_b_rdy,
    input  logic [TAGW-1:0] disp_b_tag,
    input  logic [DATW-1:0] disp_b_val,
    input  logic            disp_dvld,
    input  logic [ARCW-1:0] disp_arch,
    output logic [TAGW-1:0] disp_tag,
    output logic            iss_valid,
    output logic [TAGW-1:0] iss_tag,
    output logic [OPW-1:0]  iss_op,
    output logic [DATW-1:0] iss_a,
    output logic [DATW-1:0] iss_b,
    input  logic            cmp_valid,
    input  logic [TAGW-1:0] cmp_tag,
    input  logic [DATW-1:0] cmp_data,
    input  logic [CAUW-1:0] cmp_cause,
    output logic            cmt_valid,
    output logic [TAGW-1:0] cmt_tag,
    output logic            cmt_dvld,
    output logic [ARCW-1:0] cmt_arch,
    output logic [DATW-1:0] cmt_data,
    output logic [CAUW-1:0] cmt_cause,
    input  logic            flush_in
);

    slot_t slots_q [NSLOT];
    logic [NSLOT-1:0] rdy;
    tag_t  head, tail, pick_tag;
    logic  full, empty, pick_ok;
    logic  exc, kill, alloc;
    slot_t head_s, fresh;

    for (genvar g = 0; g < NSLOT; g++) begin : g_rdy
        assign rdy[g] = slot_ready(slots_q[g]);
    end

    dfw_pick u_pick (
        .head  (head),
        .rdy   (rdy),
        .found (pick_ok),
        .pick  (pick_tag)
    );

    assign head_s     = slots_q[head];
    assign cmt_valid  = !empty && head_s.busy && head_s.done_b && !flush_in;
    assign exc        = cmt_valid && (head_s.cause != '0);
    assign kill       = flush_in || exc;
    assign disp_ready = !full && !kill;
    assign alloc      = disp_valid && disp_ready;
    assign disp_tag   = tail;

    assign iss_valid  = pick_ok && !kill;
    assign iss_tag    = pick_tag;
    assign iss_op     = slots_q[pick_tag].op;
    assign iss_a      = slots_q[pick_tag].a.val;
    assign iss_b      = slots_q[pick_tag].b.val;

    assign cmt_tag    = head;
    assign cmt_dvld   = head_s.dvld;
    assign cmt_arch   = head_s.arch;
    assign cmt_data   = head_s.res;
    assign cmt_cause  = head_s.cause;

    dfw_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .alloc  (alloc),
        .retire (cmt_valid && !exc),
        .flush  (flush_in),
        .exc    (exc),
        .head   (head),
        .tail   (tail),
        .full   (full),
        .empty  (empty)
    );

    // new entry, with same-cycle bypass of a matching completion
    always_comb begin
        fresh        = '0;
        fresh.busy   = 1'b1;
        fresh.op     = disp_op;
        fresh.a      = snoop('{here: disp_a_rdy, tag: disp_a_tag, val: disp_a_val},
                             cmp_valid, cmp_tag, cmp_data);
        fresh.b      = snoop('{here: disp_b_rdy, tag: disp_b_tag, val: disp_b_val},
                             cmp_valid, cmp_tag, cmp_data);
        fresh.dvld   = disp_dvld;
        fresh.arch   = disp_arch;
    end

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            for (int i = 0; i < NSLOT; i++) slots_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc && (tail == tag_t'(i))) begin
                    slots_q[i] <= fresh;
                end else begin
                    if (iss_valid && (pick_tag == tag_t'(i)))
                        slots_q[i].exec_b <= 1'b1;
                    if (cmp_valid && (cmp_tag == tag_t'(i)) && slots_q[i].busy) begin
                        slots_q[i].done_b <= 1'b1;
                        slots_q[i].res    <= cmp_data;
                        slots_q[i].cause  <= cmp_cause;
                    end
                    slots_q[i].a <= snoop(slots_q[i].a, cmp_valid, cmp_tag, cmp_data);
                    slots_q[i].b <= snoop(slots_q[i].b, cmp_valid, cmp_tag, cmp_data);
                    if (cmt_valid && (head == tag_t'(i)))
                        slots_q[i].busy <= 1'b0;
                end
            end
        end
    end

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !(iss_valid && (iss_tag == $past(iss_tag)))); // R5
    AST_COMMIT_SEQ: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |=> (!cmt_valid || (cmt_tag == tag_t'($past(cmt_tag) + 1'b1)))); // R9
    AST_EXC_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && (cmt_cause != '0)) |=> (!cmt_valid && !iss_valid)); // R10
    AST_FLUSH_DRAIN: assert property (@(posedge clk) disable iff (rst)
        flush_in |=> (!cmt_valid && !iss_valid)); // R11
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        flush_in |-> (!cmt_valid && !iss_valid && !disp_ready)); // R11

endmodule

// File: tb/sim_dfw_rob.sv
module sim_dfw_rob;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid, disp_a_rdy, disp_b_rdy, disp_dvld;
    logic [5:0]  disp_op;
    logic [2:0]  disp_a_tag, disp_b_tag;
    logic [31:0] disp_a_val, disp_b_val;
    logic [4:0]  disp_arch;
    logic        cmp_valid, flush_in;
    logic [2:0]  cmp_tag;
    logic [31:0] cmp_data;
    logic [3:0]  cmp_cause;
    logic        disp_ready, iss_valid, cmt_valid, cmt_dvld;
    logic [2:0]  disp_tag, iss_tag, cmt_tag;
    logic [5:0]  iss_op;
    logic [31:0] iss_a, iss_b, cmt_data;
    logic [4:0]  cmt_arch;
    logic [3:0]  cmt_cause;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    dfw_rob u0 (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
        .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
        .disp_dvld(disp_dvld), .disp_arch(disp_arch), .disp_tag(disp_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_cause(cmp_cause),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dvld(cmt_dvld), .cmt_arch(cmt_arch),
        .cmt_data(cmt_data), .cmt_cause(cmt_cause),
        .flush_in(flush_in)
    );

    // reference model of the window
    bit          m_busy [8], m_exec [8], m_done [8], m_ah [8], m_bh [8], m_dv [8];
    logic [2:0]  m_at [8], m_bt [8];
    logic [31:0] m_av [8], m_bv [8], m_res [8];
    logic [5:0]  m_op [8];
    logic [4:0]  m_arch [8];
    logic [3:0]  m_cause [8];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic chk(string lbl, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", lbl, what, act, exp);
        end
    endtask

    task automatic idle_in();
        disp_valid = 0; disp_op = '0; disp_a_rdy = 0; disp_a_tag = '0; disp_a_val = '0;
        disp_b_rdy = 0; disp_b_tag = '0; disp_b_val = '0; disp_dvld = 0; disp_arch = '0;
        cmp_valid = 0; cmp_tag = '0; cmp_data = '0; cmp_cause = '0; flush_in = 0;
    endtask

    task automatic set_disp(logic [5:0] op, logic [31:0] va, logic [31:0] vb);
        disp_valid = 1; disp_op = op; disp_a_rdy = 1; disp_a_val = va;
        disp_b_rdy = 1; disp_b_val = vb; disp_dvld = 1; disp_arch = op[4:0];
    endtask

    // inputs are set; compare outputs against the model, then advance it
    task automatic cycle(string lbl);
        bit e_cmt, e_exc, kill, e_drdy, found;
        int pk, h;
        #1;
        h = m_head;
        e_cmt = m_busy[h] && m_done[h] && !flush_in;
        e_exc = e_cmt && (m_cause[h] != 0);
        kill  = flush_in || e_exc;
        e_drdy = (m_cnt < 8) && !kill;
        found = 0; pk = 0;
        for (int i = 0; i < 8; i++) begin
            int x = (h + i) % 8;
            if (!found && m_busy[x] && !m_exec[x] && m_ah[x] && m_bh[x]) begin
                found = 1; pk = x;
            end
        end
        chk(lbl, "R3 disp_ready", disp_ready, e_drdy);
        chk(lbl, "R2 disp_tag", disp_tag, m_tail);
        chk(lbl, "R4 iss_valid", iss_valid, found && !kill);
        if (found && !kill) begin
            chk(lbl, "R6 iss_tag", iss_tag, pk);
            chk(lbl, "R4 iss_op", iss_op, m_op[pk]);
            chk(lbl, "R7 iss_a", iss_a, m_av[pk]);
            chk(lbl, "R7 iss_b", iss_b, m_bv[pk]);
        end
        chk(lbl, "R9 cmt_valid", cmt_valid, e_cmt);
        if (e_cmt) begin
            chk(lbl, "R9 cmt_tag", cmt_tag, h);
            chk(lbl, "R9 cmt_dvld", cmt_dvld, m_dv[h]);
            chk(lbl, "R9 cmt_arch", cmt_arch, m_arch[h]);
            chk(lbl, "R9 cmt_data", cmt_data, m_res[h]);
            chk(lbl, "R10 cmt_cause", cmt_cause, m_cause[h]);
        end
        if (kill) begin
            for (int i = 0; i < 8; i++) m_busy[i] = 0;
            m_cnt = 0;
            if (flush_in) m_tail = m_head;
            else begin m_head = (m_head + 1) % 8; m_tail = m_head; end
        end else begin
            if (found) m_exec[pk] = 1;
            if (cmp_valid && m_busy[cmp_tag]) begin
                m_done[cmp_tag] = 1; m_res[cmp_tag] = cmp_data; m_cause[cmp_tag] = cmp_cause;
            end
            for (int i = 0; i < 8; i++) begin
                if (cmp_valid && !m_ah[i] && m_at[i] == cmp_tag) begin m_ah[i] = 1; m_av[i] = cmp_data; end
                if (cmp_valid && !m_bh[i] && m_bt[i] == cmp_tag) begin m_bh[i] = 1; m_bv[i] = cmp_data; end
            end
            if (e_cmt) begin m_busy[h] = 0; m_head = (m_head + 1) % 8; m_cnt--; end
            if (disp_valid && e_drdy) begin
                int t = m_tail;
                m_busy[t] = 1; m_exec[t] = 0; m_done[t] = 0; m_op[t] = disp_op;
                m_dv[t] = disp_dvld; m_arch[t] = disp_arch; m_res[t] = '0; m_cause[t] = '0;
                m_ah[t] = disp_a_rdy; m_at[t] = disp_a_tag; m_av[t] = disp_a_val;
                m_bh[t] = disp_b_rdy; m_bt[t] = disp_b_tag; m_bv[t] = disp_b_val;
                if (cmp_valid && !disp_a_rdy && disp_a_tag == cmp_tag) begin m_ah[t] = 1; m_av[t] = cmp_data; end
                if (cmp_valid && !disp_b_rdy && disp_b_tag == cmp_tag) begin m_bh[t] = 1; m_bv[t] = cmp_data; end
                m_tail = (m_tail + 1) % 8; m_cnt++;
            end
        end
        @(negedge clk);
        idle_in();
    endtask

    // pick an issued, unfinished slot to complete; returns -1 if none
    function automatic int pick_cmp();
        int n = 0, sel = -1;
        for (int i = 0; i < 8; i++)
            if (m_busy[i] && m_exec[i] && !m_done[i]) begin
                n++;
                if ($urandom_range(n - 1, 0) == 0) sel = i;
            end
        return sel;
    endfunction

    function automatic int pick_pending();
        int n = 0, sel = -1;
        for (int i = 0; i < 8; i++)
            if (m_busy[i] && !m_done[i]) begin
                n++;
                if ($urandom_range(n - 1, 0) == 0) sel = i;
            end
        return sel;
    endfunction

    task automatic rnd_in();
        int c, p;
        idle_in();
        c = pick_cmp();
        if (c >= 0 && $urandom_range(9, 0) < 6) begin
            cmp_valid = 1; cmp_tag = c[2:0]; cmp_data = $urandom();
            cmp_cause = ($urandom_range(24, 0) == 0) ? 4'($urandom_range(15, 1)) : 4'd0;
        end
        if ($urandom_range(9, 0) < 7) begin
            set_disp(6'($urandom()), $urandom(), $urandom());
            disp_dvld = 1'($urandom()); disp_arch = 5'($urandom());
            disp_a_tag = 3'($urandom()); disp_b_tag = 3'($urandom());
            p = pick_pending();
            if (p >= 0 && $urandom_range(1, 0) == 1) begin disp_a_rdy = 0; disp_a_tag = p[2:0]; end
            p = pick_pending();
            if (p >= 0 && $urandom_range(2, 0) == 0) begin disp_b_rdy = 0; disp_b_tag = p[2:0]; end
        end
        if ($urandom_range(199, 0) == 0) flush_in = 1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin
            m_busy[i] = 0; m_exec[i] = 0; m_done[i] = 0; m_ah[i] = 0; m_bh[i] = 0; m_dv[i] = 0;
            m_at[i] = '0; m_bt[i] = '0; m_av[i] = '0; m_bv[i] = '0; m_res[i] = '0;
            m_op[i] = '0; m_arch[i] = '0; m_cause[i] = '0;
        end
        idle_in();
        repeat (3) @(negedge clk);
        rst = 0;
        cycle("R1");

        // R12: ready sources, then R6/R5 oldest-first single issue
        set_disp(6'd1, 32'h11, 32'h12); cycle("R12");
        set_disp(6'd2, 32'h21, 32'h22); cycle("R12");
        set_disp(6'd3, 32'h31, 32'h32); cycle("R12");
        repeat (4) cycle("R5");

        // R3: fill past capacity while results are held back
        for (int k = 0; k < 11; k++) begin
            set_disp(6'(k + 8), 32'(k), 32'(k * 3)); cycle("R3");
        end
        // R7/R9: drain with out-of-order completions
        for (int k = 0; k < 40 && m_cnt > 0; k++) begin
            int c = pick_cmp();
            if (c >= 0) begin cmp_valid = 1; cmp_tag = c[2:0]; cmp_data = $urandom(); end
            cycle("R9");
        end

        // R8: completion forwarded into a same-cycle dispatch
        set_disp(6'd40, 32'h5, 32'h6); cycle("R8");
        begin
            int a = (m_tail + 7) % 8;
            cycle("R8");
            cmp_valid = 1; cmp_tag = a[2:0]; cmp_data = 32'hABCD;
            set_disp(6'd41, 32'h0, 32'h7); disp_a_rdy = 0; disp_a_tag = a[2:0];
            cycle("R8");
        end
        repeat (4) cycle("R8");
        for (int k = 0; k < 4; k++) begin
            int c = pick_cmp();
            if (c >= 0) begin cmp_valid = 1; cmp_tag = c[2:0]; cmp_data = 32'(k); end
            cycle("R8");
        end

        // R10: younger slot completes first, head faults
        begin
            int a = m_tail;
            int b = (m_tail + 1) % 8;
            set_disp(6'd50, 32'h1, 32'h2); cycle("R10");
            set_disp(6'd51, 32'h3, 32'h4); cycle("R10");
            cycle("R10"); cycle("R10");
            cmp_valid = 1; cmp_tag = b[2:0]; cmp_data = 32'h77; cycle("R10");
            cmp_valid = 1; cmp_tag = a[2:0]; cmp_data = 32'h66; cmp_cause = 4'd5; cycle("R10");
            repeat (3) cycle("R10");
        end

        // R11: flush with entries in flight
        set_disp(6'd60, 32'h1, 32'h2); cycle("R11");
        set_disp(6'd61, 32'h1, 32'h2); disp_a_rdy = 0; disp_a_tag = 3'(m_tail - 1); cycle("R11");
        flush_in = 1; cycle("R11");
        repeat (2) cycle("R11");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            rnd_in();
            cycle("RND");
        end
        // drain
        for (int k = 0; k < 200 && m_cnt > 0; k++) begin
            int c = pick_cmp();
            if (c >= 0) begin cmp_valid = 1; cmp_tag = c[2:0]; cmp_data = $urandom(); end
            cycle("RND");
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R9 act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule